// File: doc/BRIEF.md
# Restartable One-Minute Status Timer

This block counts a one-second timebase tick. Each time sixty counted ticks have passed, it asks the host interface for a status report. The report carries a minute-timeout flag. The flag stays set until the host acknowledges the report. Any further expiries that occur while the flag is still pending are absorbed, so only one report is requested for them.

Software controls the timer through an enable level and a one-cycle clear strobe that comes from the control-write path. Raising the enable starts a fresh minute. Lowering the enable freezes the count where it is. The clear strobe restarts the minute at any time.

A tick-accuracy input reports when the timebase is not yet trustworthy. If any tick counted during an interval arrived while that input was low, the block marks the resulting report as inexact.

Top module: `minute_status_timer`

## Requirements
- R1: After reset, `report_req`, `minute_flag` and `minute_inexact` are 0. The stored copy of the enable starts at 0, so an enable that is already high when reset is released counts as a rising edge.
- R2: While `timer_en` is 1, the 60th counted `sec_tick` after a restart makes `report_req` high for exactly one cycle, in the cycle after that tick. `minute_flag` goes to 1 in the same cycle.
- R3: After an expiry the count wraps to zero and keeps running, so expiries repeat every 60 counted ticks.
- R4: While `timer_en` is 0, `sec_tick` is ignored. No request is raised, however many ticks arrive.
- R5: A 0-to-1 change of `timer_en` restarts the count from zero. A tick in that same cycle is not counted.
- R6: A one-cycle `timer_clr` restarts the count from zero.
- R7: When `timer_clr` and an expiring tick fall in the same cycle, the clear wins. No request is raised and the next expiry comes 60 ticks later.
- R8: `minute_flag` stays at 1 until a cycle with `host_ack` high. It reads 0 from the cycle after that one.
- R9: An expiry while `minute_flag` is 1 raises no new request, and the count still wraps.
- R10: When `host_ack` and an expiry fall in the same cycle while the flag is set, no request is raised and the flag clears.
- R11: `minute_inexact` is loaded together with the flag. It is 1 when any tick counted in the expired interval (including the expiring one) arrived with `tick_exact` at 0. The acknowledge that clears the flag also clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse per second of timebase |
| timer_en | input | 1 | Timer enable level |
| timer_clr | input | 1 | One-cycle restart strobe from control write |
| tick_exact | input | 1 | 1 when the timebase tick is accurate |
| host_ack | input | 1 | Host acknowledges the pending report |
| report_req | output | 1 | One-cycle status-report request |
| minute_flag | output | 1 | Minute-timeout flag, held until acknowledged |
| minute_inexact | output | 1 | Pending report came from an inaccurate interval |

## Verification
On every cycle, the assertions check the following: the count stays in range and returns to zero after a clear or an enable edge, a disabled timer produces no expiry, the request lasts one cycle, and the request is always accompanied by the flag. They also check that the flag is held and then cleared by an acknowledge, and that a clear or an absorbed expiry produces no request. Some behaviour depends on long tick histories, and only the bench scenarios can show it: the exact 60-tick spacing after each kind of restart, the frozen count while disabled, the clear-versus-expiry and acknowledge-versus-expiry collisions, and the marking of inexact intervals.

// File: rtl/mst_pkg.sv
package mst_pkg;

  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_ZERO = 2'd1,
    CNT_STEP = 2'd2,
    CNT_WRAP = 2'd3
  } cnt_action_e;

  // Priority: restart sources first, then disabled hold, then tick step/wrap.
  function automatic cnt_action_e pick_action(input logic restart,
                                              input logic clr,
                                              input logic en,
                                              input logic tick,
                                              input logic at_last);
    if (restart || clr)   return CNT_ZERO;
    else if (!en || !tick) return CNT_HOLD;
    else if (at_last)     return CNT_WRAP;
    else                  return CNT_STEP;
  endfunction

  function automatic logic action_counts(input cnt_action_e a);
    return (a == CNT_STEP) || (a == CNT_WRAP);
  endfunction

  function automatic logic action_zeroes(input cnt_action_e a);
    return (a == CNT_ZERO) || (a == CNT_WRAP);
  endfunction

endpackage

// File: rtl/mst_en_edge.sv
module mst_en_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic restart
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en;
  end

  assign restart = en && !en_q;

  a_r5_restart_needs_high : assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> en);
  a_r5_no_double_restart : assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !restart);
endmodule

// File: rtl/mst_counter.sv
module mst_counter
  import mst_pkg::*;
#(
  parameter int TICKS = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic clr,
  input  logic en,
  input  logic tick,
  output logic expire,
  output logic counted,
  output logic zeroing
);
  localparam int CW = (TICKS > 2) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;
  logic          at_last;
  cnt_action_e   act;

  function automatic logic [CW-1:0] next_count(input cnt_action_e a,
                                               input logic [CW-1:0] c);
    case (a)
      CNT_ZERO, CNT_WRAP: return '0;
      CNT_STEP:           return c + 1'b1;
      default:            return c;
    endcase
  endfunction

  assign at_last = (cnt == LAST);
  assign act     = pick_action(restart, clr, en, tick, at_last);
  assign expire  = (act == CNT_WRAP);
  assign counted = action_counts(act);
  assign zeroing = action_zeroes(act);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= next_count(act, cnt);
  end

  a_r3_count_range : assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  a_r6_clear_zeroes : assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);
  a_r5_edge_zeroes : assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt == '0);
  a_r4_disabled_frozen : assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(cnt));
  a_r4_disabled_no_expire : assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !expire);
  a_r7_clear_blocks_expire : assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !expire);
endmodule

// File: rtl/mst_report.sv
module mst_report (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic counted,
  input  logic zeroing,
  input  logic exact,
  input  logic ack,
  output logic req,
  output logic flag,
  output logic inexact
);
  logic accept;
  logic rough_tick;
  logic rough_acc;

  assign accept     = expire && !flag;
  assign rough_tick = counted && !exact;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req       <= 1'b0;
      flag      <= 1'b0;
      inexact   <= 1'b0;
      rough_acc <= 1'b0;
    end else begin
      req  <= accept;
      flag <= accept || (flag && !ack);
      if (accept)          inexact <= rough_acc || rough_tick;
      else if (ack && flag) inexact <= 1'b0;
      if (zeroing)         rough_acc <= 1'b0;
      else if (rough_tick) rough_acc <= 1'b1;
    end
  end

  a_r2_req_one_cycle : assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);
  a_r2_req_with_flag : assert property (@(posedge clk) disable iff (!rst_n)
    req |-> flag);
  a_r8_flag_held : assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !ack) |=> flag);
  a_r8_ack_clears : assert property (@(posedge clk) disable iff (!rst_n)
    (flag && ack) |=> !flag);
  a_r9_absorbed_expiry : assert property (@(posedge clk) disable iff (!rst_n)
    (expire && flag) |=> !req);
  a_r11_inexact_only_pending : assert property (@(posedge clk) disable iff (!rst_n)
    inexact |-> flag);
endmodule

// File: rtl/minute_status_timer.sv
module minute_status_timer #(
  parameter int TICKS_PER_MINUTE = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick,
  input  logic timer_en,
  input  logic timer_clr,
  input  logic tick_exact,
  input  logic host_ack,
  output logic report_req,
  output logic minute_flag,
  output logic minute_inexact
);
  logic restart;
  logic expire;
  logic counted;
  logic zeroing;

  mst_en_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (timer_en),
    .restart (restart)
  );

  mst_counter #(.TICKS(TICKS_PER_MINUTE)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .clr     (timer_clr),
    .en      (timer_en),
    .tick    (sec_tick),
    .expire  (expire),
    .counted (counted),
    .zeroing (zeroing)
  );

  mst_report u_rep (
    .clk     (clk),
    .rst_n   (rst_n),
    .expire  (expire),
    .counted (counted),
    .zeroing (zeroing),
    .exact   (tick_exact),
    .ack     (host_ack),
    .req     (report_req),
    .flag    (minute_flag),
    .inexact (minute_inexact)
  );

  a_r7_clear_no_req : assert property (@(posedge clk) disable iff (!rst_n)
    timer_clr |=> !report_req);
  a_r1_outputs_low_after_reset : assert property (@(posedge clk)
    $rose(rst_n) |-> (!report_req && !minute_flag && !minute_inexact));
endmodule

// File: tb/minute_status_timer_test.sv
module minute_status_timer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick = 1'b0, timer_en = 1'b0, timer_clr = 1'b0;
  logic tick_exact = 1'b1, host_ack = 1'b0;
  logic report_req, minute_flag, minute_inexact;
  int checks = 0, failures = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  minute_status_timer uut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .timer_en(timer_en),
    .timer_clr(timer_clr), .tick_exact(tick_exact), .host_ack(host_ack),
    .report_req(report_req), .minute_flag(minute_flag),
    .minute_inexact(minute_inexact)
  );

  typedef struct packed {
    logic ack_first;
    int   ticks;
    logic exp_req;
    logic exp_flag;
  } vec_t;

  // R2/R3/R8/R9 walk: counts restart at 0 when the walk begins.
  localparam vec_t VEC [6] = '{
    '{1'b0, 59, 1'b0, 1'b0},
    '{1'b0,  1, 1'b1, 1'b1},
    '{1'b0, 60, 1'b0, 1'b1},
    '{1'b1, 59, 1'b0, 1'b0},
    '{1'b0,  1, 1'b1, 1'b1},
    '{1'b1, 60, 1'b1, 1'b1}
  };

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // One tick cycle; outputs are sampled after the edge that consumed it.
  task automatic one_tick(input logic ack, input logic clr, input logic exact);
    sec_tick = 1'b1; host_ack = ack; timer_clr = clr; tick_exact = exact;
    @(negedge clk);
    sec_tick = 1'b0; host_ack = 1'b0; timer_clr = 1'b0; tick_exact = 1'b1;
  endtask

  task automatic ticks(input int n, output logic saw);
    saw = 1'b0;
    for (int i = 0; i < n; i++) begin
      one_tick(1'b0, 1'b0, 1'b1);
      if (report_req) saw = 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic pulse_ack();
    host_ack = 1'b1; @(negedge clk); host_ack = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_clr();
    timer_clr = 1'b1; @(negedge clk); timer_clr = 1'b0; @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic saw;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 req after reset", report_req, 1'b0);
    check("R1 flag after reset", minute_flag, 1'b0);
    check("R1 inexact after reset", minute_inexact, 1'b0);

    timer_en = 1'b1; @(negedge clk);
    for (int v = 0; v < 6; v++) begin
      if (VEC[v].ack_first) pulse_ack();
      ticks(VEC[v].ticks - 1, saw);
      check($sformatf("R3 no early req vec%0d", v), saw, 1'b0);
      one_tick(1'b0, 1'b0, 1'b1);
      check($sformatf("R2 req vec%0d", v), report_req, VEC[v].exp_req);
      check($sformatf("R9 flag vec%0d", v), minute_flag, VEC[v].exp_flag);
      @(negedge clk);
      check($sformatf("R2 req one cycle vec%0d", v), report_req, 1'b0);
    end
    check("R8 flag held without ack", minute_flag, 1'b1);
    pulse_ack();
    check("R8 flag cleared by ack", minute_flag, 1'b0);

    // R7: clear coincides with expiring tick
    pulse_clr();
    ticks(59, saw);
    one_tick(1'b0, 1'b1, 1'b1);
    check("R7 clear beats expiry", report_req, 1'b0);
    @(negedge clk);
    ticks(59, saw);
    check("R7 no req before 60 after clear", saw, 1'b0);
    one_tick(1'b0, 1'b0, 1'b1);
    check("R7 req 60 ticks after clear", report_req, 1'b1);
    @(negedge clk); pulse_ack();

    // R6: clear mid-interval
    ticks(30, saw);
    pulse_clr();
    ticks(59, saw);
    check("R6 no req after clear restart", saw, 1'b0);
    one_tick(1'b0, 1'b0, 1'b1);
    check("R6 req 60 after clear", report_req, 1'b1);
    @(negedge clk); pulse_ack();

    // R4 / R5: disable ignores ticks, rising enable restarts
    ticks(40, saw);
    timer_en = 1'b0; @(negedge clk);
    ticks(30, saw);
    check("R4 ticks ignored while disabled", saw, 1'b0);
    check("R4 flag stays clear while disabled", minute_flag, 1'b0);
    timer_en = 1'b1; @(negedge clk);
    ticks(59, saw);
    check("R5 no req before 60 after enable edge", saw, 1'b0);
    one_tick(1'b0, 1'b0, 1'b1);
    check("R5 req 60 after enable edge", report_req, 1'b1);
    @(negedge clk);

    // R10: ack and expiry together while flag pending
    ticks(59, saw);
    one_tick(1'b1, 1'b0, 1'b1);
    check("R10 no req on ack+expiry", report_req, 1'b0);
    check("R10 flag cleared on ack+expiry", minute_flag, 1'b0);
    @(negedge clk);
    ticks(59, saw);
    one_tick(1'b0, 1'b0, 1'b1);
    check("R10 next minute still requests", report_req, 1'b1);
    @(negedge clk); pulse_ack();

    // R11: inexact interval marking
    ticks(10, saw);
    one_tick(1'b0, 1'b0, 1'b0); @(negedge clk);
    ticks(48, saw);
    one_tick(1'b0, 1'b0, 1'b1);
    check("R11 req on rough interval", report_req, 1'b1);
    check("R11 inexact set", minute_inexact, 1'b1);
    @(negedge clk); pulse_ack();
    check("R11 inexact cleared by ack", minute_inexact, 1'b0);
    ticks(59, saw);
    one_tick(1'b0, 1'b0, 1'b1);
    check("R11 exact interval not marked", minute_inexact, 1'b0);
    @(negedge clk); pulse_ack();

    // R1: enable held high through reset counts as an edge
    rst_n = 1'b0; timer_en = 1'b1;
    ticks(5, saw);
    rst_n = 1'b1; @(negedge clk);
    ticks(59, saw);
    check("R1 no req before 60 after reset with enable", saw, 1'b0);
    one_tick(1'b0, 1'b0, 1'b1);
    check("R1 req 60 after reset with enable", report_req, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule